// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a processor's store port and the write port of a memory. It gathers stores that walk forward byte by byte through one cache line into a single line-sized staging buffer. It then sends that buffer to memory as one masked line write. Each store has a byte address, a size code and up to eight bytes of data. A store that begins exactly where the previous one ended, inside the same line, is merged. Any other store sends the staged line out first and then starts a new buffer of its own.

A line goes out in four cases: when every byte of it has been written, when a store breaks the run, when the flush input is raised, or when the buffer has sat with no new store for a set number of cycles. While a line write waits on the memory side, the store port is held off, so no accepted store is lost. A store that would run past the end of its line is refused and flagged. It still forces out whatever was staged.

Top module: `wc_store_buffer`

## Requirements
- R1: After reset the write port is idle, the store port is ready, the error flag is low and the buffer is empty. A flush of an empty buffer emits nothing.
- R2: The size code selects the store width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Store byte k is taken from st_data_i[8k+7:8k] and lands at line offset (address mod 64) + k. Store data bytes at or above the store width are ignored.
- R3: A store whose address equals the previous store's address plus its width, and that lies in the same 64-byte line, is merged into the open buffer without emitting anything.
- R4: Once all 64 bytes of the open line have been written, the line is emitted as a single write with every mask bit set, and the buffer becomes empty.
- R5: A store that is not consecutive (a gap, a repeat, or a consecutive address that falls in the next line) first emits the open buffer. The store then opens a new buffer on its own line.
- R6: In an emitted write, wr_line_o is the byte address shifted right by 6 and bit i of wr_mask_o is set only for line byte i that was written. The data of unwritten bytes is zero.
- R7: A store with (address mod 64) + width > 64 is accepted but discarded. st_err_o is high for exactly the one cycle after it is accepted, any open buffer is emitted, and the buffer is left empty.
- R8: While flush_i is high the store port is not ready. When no write is pending, a non-empty buffer is emitted.
- R9: If the buffer is open and no store is accepted for IDLE_LIMIT cycles after the last accepted store, the buffer is emitted. wr_valid_o rises on the IDLE_LIMIT-th rising edge after the edge that accepted that store.
- R10: While wr_valid_o is high the store port is not ready. The write payload stays stable until wr_ready_i is seen high, and stores held off during the stall are accepted and merged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store port can accept |
| st_addr_i | input | AW | Store byte address |
| st_size_i | input | 2 | Store width code |
| st_data_i | input | 64 | Store data, low bytes first |
| st_err_o | output | 1 | Store refused for crossing a line |
| flush_i | input | 1 | Force out the staged line |
| wr_valid_o | output | 1 | Line write valid |
| wr_ready_i | input | 1 | Memory accepts the line write |
| wr_line_o | output | AW-6 | Line index of the write |
| wr_data_o | output | 512 | Line data |
| wr_mask_o | output | 64 | Byte enables of the line write |

## Verification
The properties assume the memory side samples the payload only while wr_valid_o is high. They also assume the store side holds its request only for the cycles it chooses to drive, with no rule that it stay stable while stalled, so they constrain only what the block drives. The stimulus raises st_valid_i only after it has seen st_ready_o high and keeps each request to exactly one cycle. It changes every input on the falling edge and reads results on the falling edge, or at the rising edge before any register updates. A single-store sweep covers every line offset with every width, which reaches each crossing case. Full-line runs, run breaks, stalls and idle expiry are checked against byte images that the bench builds itself.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } st_size_e;

    // width in bytes encoded by a store size code
    function automatic int unsigned size_to_bytes(input logic [1:0] code);
        return 32'd1 << code;
    endfunction
endpackage

// File: rtl/wc_store_decode.sv
module wc_store_decode #(
    parameter int AW    = 32,
    parameter int LB    = 64,
    parameter int SB    = 8,
    localparam int OFF_W  = $clog2(LB),
    localparam int LINE_W = AW - OFF_W,
    localparam int CNT_W  = $clog2(SB) + 1
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [1:0]        size_i,
    output logic [OFF_W-1:0]  off_o,
    output logic [LINE_W-1:0] line_o,
    output logic [CNT_W-1:0]  nbytes_o,
    output logic [AW-1:0]     next_o,
    output logic              cross_o
);
    logic [OFF_W:0] end_off;

    always_comb begin
        off_o    = addr_i[OFF_W-1:0];
        line_o   = addr_i[AW-1:OFF_W];
        nbytes_o = CNT_W'(wc_pkg::size_to_bytes(size_i));
        next_o   = addr_i + AW'(nbytes_o);
        end_off  = {1'b0, off_o} + (OFF_W+1)'(nbytes_o);
        cross_o  = end_off > (OFF_W+1)'(LB);
    end
endmodule

// File: rtl/wc_lane_place.sv
module wc_lane_place #(
    parameter int LB = 64,
    parameter int SB = 8,
    localparam int OFF_W = $clog2(LB),
    localparam int CNT_W = $clog2(SB) + 1,
    localparam int SEL_W = $clog2(SB)
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic [SB*8-1:0]  sdata_i,
    output logic [LB*8-1:0]  ldata_o,
    output logic [LB-1:0]    lmask_o
);
    for (genvar b = 0; b < LB; b++) begin : g_lane
        logic [OFF_W:0] rel;
        logic [SEL_W-1:0] sel;
        logic hit;
        always_comb begin
            rel = (OFF_W+1)'(b) - {1'b0, off_i};
            sel = rel[SEL_W-1:0];
            hit = ((OFF_W+1)'(b) >= {1'b0, off_i}) && (rel < (OFF_W+1)'(nbytes_i));
            lmask_o[b]         = hit;
            ldata_o[b*8 +: 8]  = hit ? sdata_i[{sel, 3'b000} +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/wc_idle_timer.sv
module wc_idle_timer #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    output logic expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = (cnt_q == CW'(LIMIT - 1));
        cnt_d     = cnt_q;
        if (clear_i)         cnt_d = '0;
        else if (!expired_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wc_store_buffer.sv
module wc_store_buffer #(
    parameter int AW         = 32,
    parameter int LB         = 64,
    parameter int SB         = 8,
    parameter int IDLE_LIMIT = 16,
    localparam int OFF_W  = $clog2(LB),
    localparam int LINE_W = AW - OFF_W,
    localparam int CNT_W  = $clog2(SB) + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              st_valid_i,
    output logic              st_ready_o,
    input  logic [AW-1:0]     st_addr_i,
    input  logic [1:0]        st_size_i,
    input  logic [SB*8-1:0]   st_data_i,
    output logic              st_err_o,
    input  logic              flush_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [LINE_W-1:0] wr_line_o,
    output logic [LB*8-1:0]   wr_data_o,
    output logic [LB-1:0]     wr_mask_o
);
    typedef struct packed {
        logic              open;
        logic [LINE_W-1:0] line;
        logic [AW-1:0]     next;
        logic [LB-1:0]     mask;
        logic [LB*8-1:0]   data;
        logic              ov;
        logic [LINE_W-1:0] o_line;
        logic [LB*8-1:0]   o_data;
        logic [LB-1:0]     o_mask;
        logic              err;
    } wc_state_t;

    wc_state_t s_d, s_q;

    logic [OFF_W-1:0]  st_off;
    logic [LINE_W-1:0] st_line;
    logic [CNT_W-1:0]  st_nbytes;
    logic [AW-1:0]     st_next;
    logic              st_cross;
    logic [LB*8-1:0]   put_data;
    logic [LB-1:0]     put_mask;
    logic              idle_exp;
    logic              st_fire;
    logic              consec;
    logic [LB-1:0]     mrg_mask;
    logic [LB*8-1:0]   mrg_data;

    wc_store_decode #(.AW(AW), .LB(LB), .SB(SB)) u_dec (
        .addr_i   (st_addr_i),
        .size_i   (st_size_i),
        .off_o    (st_off),
        .line_o   (st_line),
        .nbytes_o (st_nbytes),
        .next_o   (st_next),
        .cross_o  (st_cross)
    );

    wc_lane_place #(.LB(LB), .SB(SB)) u_place (
        .off_i    (st_off),
        .nbytes_i (st_nbytes),
        .sdata_i  (st_data_i),
        .ldata_o  (put_data),
        .lmask_o  (put_mask)
    );

    wc_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clear_i   (st_fire || !s_q.open),
        .expired_o (idle_exp)
    );

    assign st_ready_o = !s_q.ov && !flush_i;
    assign st_fire    = st_valid_i && st_ready_o;
    assign st_err_o   = s_q.err;
    assign wr_valid_o = s_q.ov;
    assign wr_line_o  = s_q.o_line;
    assign wr_data_o  = s_q.o_data;
    assign wr_mask_o  = s_q.o_mask;

    always_comb begin
        s_d      = s_q;
        s_d.err  = 1'b0;
        consec   = s_q.open && (st_addr_i == s_q.next) && (st_line == s_q.line);
        mrg_mask = s_q.mask | put_mask;
        mrg_data = s_q.data | put_data;

        if (s_q.ov && wr_ready_i) s_d.ov = 1'b0;

        if (!s_q.ov) begin
            if (st_fire) begin
                if (st_cross) begin
                    if (s_q.open) begin
                        s_d.ov     = 1'b1;
                        s_d.o_line = s_q.line;
                        s_d.o_data = s_q.data;
                        s_d.o_mask = s_q.mask;
                    end
                    s_d.open = 1'b0;
                    s_d.mask = '0;
                    s_d.data = '0;
                    s_d.err  = 1'b1;
                end else if (consec) begin
                    if (&mrg_mask) begin
                        s_d.ov     = 1'b1;
                        s_d.o_line = s_q.line;
                        s_d.o_data = mrg_data;
                        s_d.o_mask = mrg_mask;
                        s_d.open   = 1'b0;
                        s_d.mask   = '0;
                        s_d.data   = '0;
                    end else begin
                        s_d.mask = mrg_mask;
                        s_d.data = mrg_data;
                        s_d.next = st_next;
                    end
                end else begin
                    if (s_q.open) begin
                        s_d.ov     = 1'b1;
                        s_d.o_line = s_q.line;
                        s_d.o_data = s_q.data;
                        s_d.o_mask = s_q.mask;
                    end
                    s_d.open = 1'b1;
                    s_d.line = st_line;
                    s_d.next = st_next;
                    s_d.mask = put_mask;
                    s_d.data = put_data;
                end
            end else if (s_q.open && (flush_i || idle_exp)) begin
                s_d.ov     = 1'b1;
                s_d.o_line = s_q.line;
                s_d.o_data = s_q.data;
                s_d.o_mask = s_q.mask;
                s_d.open   = 1'b0;
                s_d.mask   = '0;
                s_d.data   = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end
endmodule

// File: rtl/wc_store_buffer_chk.sv
module wc_store_buffer_chk #(
    parameter int AW = 32,
    parameter int LB = 64,
    parameter int SB = 8,
    localparam int LINE_W = AW - $clog2(LB)
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              st_valid_i,
    input logic              st_ready_o,
    input logic              st_err_o,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [LINE_W-1:0] wr_line_o,
    input logic [LB*8-1:0]   wr_data_o,
    input logic [LB-1:0]     wr_mask_o
);
    // R10
    hold_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_valid_o && !wr_ready_i |=> wr_valid_o);

    // R10
    payload_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_valid_o && !wr_ready_i |=> $stable(wr_data_o) && $stable(wr_mask_o) && $stable(wr_line_o));

    // R10
    no_accept_pending_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_valid_i && st_ready_o |-> !wr_valid_o);

    // R1
    no_empty_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wr_valid_o) |-> (wr_mask_o != '0));

    // R7
    err_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_err_o |-> $past(st_valid_i && st_ready_o));

    // R7
    err_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_err_o |=> !st_err_o || $past(st_valid_i && st_ready_o));
endmodule

bind wc_store_buffer wc_store_buffer_chk #(.AW(AW), .LB(LB), .SB(SB)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .st_valid_i (st_valid_i),
    .st_ready_o (st_ready_o),
    .st_err_o   (st_err_o),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_line_o  (wr_line_o),
    .wr_data_o  (wr_data_o),
    .wr_mask_o  (wr_mask_o)
);

// File: tb/test_wc_store_buffer.sv
module test_wc_store_buffer;
    localparam int AW = 32;
    localparam int LB = 64;
    localparam int IL = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [31:0]   st_addr = '0;
    logic [1:0]    st_size = '0;
    logic [63:0]   st_data = '0;
    logic          st_err;
    logic          flush = 1'b0;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [25:0]   wr_line;
    logic [511:0]  wr_data;
    logic [63:0]   wr_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [511:0] r_data [8];
    logic [63:0]  r_mask [8];
    logic [25:0]  r_line [8];
    int r_n = 0;

    logic [511:0] e_data [4];
    logic [63:0]  e_mask [4];
    logic [25:0]  e_line [4];

    always #5 clk = ~clk;

    wc_store_buffer #(.AW(AW), .LB(LB), .SB(8), .IDLE_LIMIT(IL)) i_wc_store_buffer (
        .clk_i      (clk),
        .rst_i      (rst),
        .st_valid_i (st_valid),
        .st_ready_o (st_ready),
        .st_addr_i  (st_addr),
        .st_size_i  (st_size),
        .st_data_i  (st_data),
        .st_err_o   (st_err),
        .flush_i    (flush),
        .wr_valid_o (wr_valid),
        .wr_ready_i (wr_ready),
        .wr_line_o  (wr_line),
        .wr_data_o  (wr_data),
        .wr_mask_o  (wr_mask)
    );

    // capture every completed line write just before the edge that takes it
    always @(posedge clk) begin
        if (!rst && wr_valid && wr_ready) begin
            if (r_n < 8) begin
                r_data[r_n] = wr_data;
                r_mask[r_n] = wr_mask;
                r_line[r_n] = wr_line;
            end
            r_n = r_n + 1;
        end
    end

    function automatic logic [7:0] pat(input int a, input int tag);
        return 8'(a * 5 + tag * 29 + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 4; i++) begin
            e_data[i] = '0;
            e_mask[i] = '0;
            e_line[i] = '0;
        end
        r_n = 0;
    endtask

    task automatic exp_add(input int i, input int a, input int sz, input int tag);
        for (int k = 0; k < (1 << sz); k++) begin
            e_data[i][((a + k) % 64) * 8 +: 8] = pat(a + k, tag);
            e_mask[i][(a + k) % 64] = 1'b1;
        end
        e_line[i] = 26'(a >> 6);
    endtask

    task automatic do_store(input int a, input int sz, input int tag, output bit err);
        logic [63:0] d;
        d = {8{8'hA5}};
        for (int k = 0; k < (1 << sz); k++) d[k*8 +: 8] = pat(a + k, tag);
        while (!st_ready) @(negedge clk);
        st_valid = 1'b1;
        st_addr  = 32'(a);
        st_size  = 2'(sz);
        st_data  = d;
        @(negedge clk);
        st_valid = 1'b0;
        st_data  = '0;
        err      = st_err;
    endtask

    task automatic do_flush();
        while (wr_valid) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_rec(input int ri, input int ei, input string req);
        chk(r_line[ri] == e_line[ei], req, "line", 512'(r_line[ri]), 512'(e_line[ei]));
        chk(r_mask[ri] == e_mask[ei], req, "mask", 512'(r_mask[ri]), 512'(e_mask[ei]));
        chk(r_data[ri] == e_data[ei], req, "data", r_data[ri], e_data[ei]);
    endtask

    initial begin
        bit e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(wr_valid == 1'b0, "R1", "wr_valid after reset", 512'(wr_valid), 512'(0));
        chk(st_ready == 1'b1, "R1", "st_ready after reset", 512'(st_ready), 512'(1));
        chk(st_err == 1'b0, "R1", "st_err after reset", 512'(st_err), 512'(0));
        clear_exp();
        do_flush();
        chk(r_n == 0, "R1", "writes from empty flush", 512'(r_n), 512'(0));

        // R3 R4: fill whole lines with each store width
        for (int sz = 0; sz < 4; sz++) begin
            int base;
            base = 32'h1000 + sz * 64;
            clear_exp();
            for (int off = 0; off < 64; off += (1 << sz)) begin
                do_store(base + off, sz, sz, e);
                exp_add(0, base + off, sz, sz);
            end
            @(negedge clk);
            @(negedge clk);
            chk(r_n == 1, "R4", "full-line write count", 512'(r_n), 512'(1));
            chk(r_mask[0] == '1, "R4", "full mask", 512'(r_mask[0]), 512'({64{1'b1}}));
            chk_rec(0, 0, "R3");
            do_flush();
            chk(r_n == 1, "R4", "buffer empty after full write", 512'(r_n), 512'(1));
        end

        // R2 R6 R7: every offset with every width, single store then flush
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 64; off++) begin
                int a;
                a = 32'h2000 + off;
                clear_exp();
                do_store(a, sz, off + sz, e);
                if (off + (1 << sz) > 64) begin
                    chk(e == 1'b1, "R7", "err on crossing store", 512'(e), 512'(1));
                    @(negedge clk);
                    chk(st_err == 1'b0, "R7", "err one cycle only", 512'(st_err), 512'(0));
                    do_flush();
                    chk(r_n == 0, "R7", "crossing store discarded", 512'(r_n), 512'(0));
                end else begin
                    chk(e == 1'b0, "R2", "no err on in-line store", 512'(e), 512'(0));
                    exp_add(0, a, sz, off + sz);
                    do_flush();
                    chk(r_n == 1, "R8", "flush write count", 512'(r_n), 512'(1));
                    chk_rec(0, 0, "R6");
                end
            end
        end

        // R5: gap in same line, then a new line
        clear_exp();
        do_store(32'h3008, 2, 1, e); exp_add(0, 32'h3008, 2, 1);
        do_store(32'h300C, 2, 1, e); exp_add(0, 32'h300C, 2, 1);
        do_store(32'h3020, 1, 2, e); exp_add(1, 32'h3020, 1, 2);
        do_store(32'h3022, 0, 2, e); exp_add(1, 32'h3022, 0, 2);
        do_store(32'h5000, 3, 3, e); exp_add(2, 32'h5000, 3, 3);
        do_flush();
        chk(r_n == 3, "R5", "break write count", 512'(r_n), 512'(3));
        chk_rec(0, 0, "R5");
        chk_rec(1, 1, "R5");
        chk_rec(2, 2, "R5");

        // R5: consecutive address spilling into the next line
        clear_exp();
        do_store(32'h6038, 3, 4, e); exp_add(0, 32'h6038, 3, 4);
        do_store(32'h6040, 3, 5, e); exp_add(1, 32'h6040, 3, 5);
        do_flush();
        chk(r_n == 2, "R5", "next-line write count", 512'(r_n), 512'(2));
        chk_rec(0, 0, "R5");
        chk_rec(1, 1, "R5");

        // R5: repeated address is not consecutive
        clear_exp();
        do_store(32'h7000, 0, 6, e); exp_add(0, 32'h7000, 0, 6);
        do_store(32'h7000, 0, 7, e); exp_add(1, 32'h7000, 0, 7);
        do_flush();
        chk(r_n == 2, "R5", "repeat write count", 512'(r_n), 512'(2));
        chk_rec(0, 0, "R5");
        chk_rec(1, 1, "R5");

        // R7: crossing store with an open buffer
        clear_exp();
        do_store(32'h8000, 3, 8, e); exp_add(0, 32'h8000, 3, 8);
        do_store(32'h803E, 2, 9, e);
        chk(e == 1'b1, "R7", "err with open buffer", 512'(e), 512'(1));
        do_flush();
        chk(r_n == 1, "R7", "open buffer sent, store dropped", 512'(r_n), 512'(1));
        chk_rec(0, 0, "R7");

        // R9: idle expiry timing
        clear_exp();
        do_store(32'h9000, 1, 10, e); exp_add(0, 32'h9000, 1, 10);
        repeat (IL - 1) @(negedge clk);
        chk(wr_valid == 1'b0, "R9", "not yet expired", 512'(wr_valid), 512'(0));
        @(negedge clk);
        chk(wr_valid == 1'b1, "R9", "expired", 512'(wr_valid), 512'(1));
        @(negedge clk);
        chk(r_n == 1, "R9", "idle write count", 512'(r_n), 512'(1));
        chk_rec(0, 0, "R9");

        // R10: stall holds the write and the store port
        clear_exp();
        wr_ready = 1'b0;
        do_store(32'hA000, 3, 11, e); exp_add(0, 32'hA000, 3, 11);
        do_store(32'hB000, 3, 12, e); exp_add(1, 32'hB000, 3, 12);
        exp_add(1, 32'hB008, 3, 12);
        fork
            do_store(32'hB008, 3, 12, e);
            begin
                for (int c = 0; c < 5; c++) begin
                    chk(wr_valid == 1'b1, "R10", "valid held", 512'(wr_valid), 512'(1));
                    chk(st_ready == 1'b0, "R10", "store port held", 512'(st_ready), 512'(0));
                    chk(wr_mask == e_mask[0], "R10", "mask stable", 512'(wr_mask), 512'(e_mask[0]));
                    @(negedge clk);
                end
                wr_ready = 1'b1;
            end
        join
        do_flush();
        chk(r_n == 2, "R10", "stall write count", 512'(r_n), 512'(2));
        chk_rec(0, 0, "R10");
        chk_rec(1, 1, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule